// File: doc/BRIEF.md
# Base Address Register Window and Address Decoder

This block is the address-window part of a peripheral's configuration header. It keeps six base address registers and a 16-bit command register. Software reads and writes them through a simple configuration port. Writing all ones to a base register and reading it back returns that region's size mask in the usual way.

Slot 0 is a one-byte I/O region and slot 1 is a 256-byte memory region that decodes in 32-bit space. Slots 2 to 5 are not implemented. A second, independent port takes an incoming access address. It reports which slot the address falls in and the byte offset inside that slot, so the data path behind the block can steer the access. All reads and the decode are combinational. Configuration writes take effect at the next rising clock edge.

Top module: `bar_cfg_decode`

## Requirements
- R1: After reset, every base register and the command register read 0 at configuration offsets 0x04 and 0x10 to 0x24.
- R2: A write to offset 0x04 stores bits 15:0 of the write data into the command register. A read there returns those 16 bits with bits 31:16 zero, whatever was written in the upper half.
- R3: A write to offset 0x10 (slot 0, I/O) stores the written word with bit 0 forced to 1. Once written, slot 0 always reads back with bit 0 set.
- R4: A write to offset 0x14 (slot 1, memory) stores the written word unchanged. Any stored value other than all ones reads back exactly as stored.
- R5: Offsets 0x18, 0x1C, 0x20 and 0x24 (slots 2 to 5) ignore writes and always read 0.
- R6: When slot 0 holds all ones, it reads 0xFFFFFFFD: the inverted size minus one, with bits 1:0 cleared and then bit 0 set. Writing 0xFFFFFFFE also produces this, because bit 0 is forced.
- R7: When slot 1 holds all ones, it reads 0xFFFFFF00: the inverted size minus one, with bits 3:0 cleared. The type field in bits 2:1 reads 00, which means 32-bit memory.
- R8: An access address hits a slot when base <= address < base + size. The base is the stored value with bit 0 cleared. On a hit, dec_hit is 1, dec_idx is the slot number and dec_off is the address minus the base.
- R9: When more than one slot contains the address, the lowest-numbered slot is reported.
- R10: When no slot contains the address, dec_hit, dec_idx and dec_off are all 0. Slots of size 0 (slots 2 to 5) never hit.
- R11: Writes to any offset other than 0x04, 0x10 and 0x14, including offsets that are not a multiple of 4, change no register. Reads at such offsets return 0.
- R12: The upper bound base + size is formed one bit wider than the address, so a region that reaches the top of the address space still covers its last addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears all registers |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_addr |
| acc_addr | input | 32 | Access address to decode |
| dec_hit | output | 1 | Access address falls in a slot |
| dec_idx | output | 3 | Number of the slot that was hit |
| dec_off | output | 32 | Byte offset of the access inside the slot |

## Verification
The checker assumes that cfg_addr, cfg_we and cfg_wdata are stable around each rising edge. It also assumes that rst_n is held low for at least one edge before the inputs are used. It keeps its own copy of the command register and a flag for slot 0 having been written. Its properties only tie read data to those copies and to the configured offsets. The stimulus changes every input on the falling edge and holds each write strobe for exactly one rising edge. Decode addresses are chosen so that exact boundaries, overlapping slots and the top of the address space are all reached.

// File: rtl/barcfg_pkg.sv
package barcfg_pkg;

   // Kind of region a slot decodes
   typedef enum logic [1:0] {
      SP_NONE  = 2'd0,
      SP_IO    = 2'd1,
      SP_MEM32 = 2'd2
   } space_e;

   // Address bits that are not part of the base, per region kind
   localparam int unsigned IO_FLAG_BITS  = 2;
   localparam int unsigned MEM_FLAG_BITS = 4;

endpackage

// File: rtl/bar_slot.sv
module bar_slot
   import barcfg_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter space_e      SPACE  = SP_IO,
   parameter int unsigned SIZE   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wdata,
   output logic [ADDR_W-1:0] rd_value,
   input  logic [ADDR_W-1:0] acc_addr,
   output logic              hit,
   output logic [ADDR_W-1:0] offset
);

   localparam int unsigned FLAG_BITS = (SPACE == SP_IO) ? IO_FLAG_BITS : MEM_FLAG_BITS;
   localparam logic [ADDR_W-1:0] FLAG_CLR  = ~ADDR_W'((1 << FLAG_BITS) - 1);
   localparam logic [ADDR_W-1:0] SPACE_BIT = ADDR_W'(SPACE == SP_IO);
   localparam logic [ADDR_W-1:0] SIZE_M1   = ADDR_W'(SIZE - 1);
   localparam logic [ADDR_W-1:0] PROBE_VAL = (~SIZE_M1 & FLAG_CLR) | SPACE_BIT;
   localparam logic [ADDR_W:0]   SIZE_X    = (ADDR_W + 1)'(SIZE);

   if (SIZE == 0 || (SIZE & (SIZE - 1)) != 0) begin : g_bad_size
      $error("bar_slot: SIZE must be a nonzero power of two");
   end
   if (SPACE == SP_NONE) begin : g_bad_space
      $error("bar_slot: an implemented slot needs an I/O or memory space");
   end
   if (ADDR_W < 8) begin : g_bad_width
      $error("bar_slot: ADDR_W too small");
   end

   logic [ADDR_W-1:0] stored_q;
   logic [ADDR_W:0]   base_x;
   logic [ADDR_W:0]   limit_x;
   logic [ADDR_W:0]   addr_x;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stored_q <= '0;
      end else if (wr_en) begin
         stored_q <= wdata | SPACE_BIT;
      end
   end

   // All ones is the sizing probe: answer with the size mask
   assign rd_value = (stored_q == '1) ? PROBE_VAL : stored_q;

   // Range test one bit wider than the address so the bound never wraps
   assign base_x  = {1'b0, stored_q[ADDR_W-1:1], 1'b0};
   assign limit_x = base_x + SIZE_X;
   assign addr_x  = {1'b0, acc_addr};
   assign hit     = (addr_x >= base_x) && (addr_x < limit_x);
   assign offset  = acc_addr - base_x[ADDR_W-1:0];

endmodule

// File: rtl/bar_first_hit.sv
module bar_first_hit #(
   parameter int unsigned N      = 6,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned IDX_W  = 3
) (
   input  logic [N-1:0]             hit_vec,
   input  logic [N-1:0][ADDR_W-1:0] off_vec,
   output logic                     hit,
   output logic [IDX_W-1:0]         idx,
   output logic [ADDR_W-1:0]        off
);

   // Walk downward so the lowest-numbered hitting slot is the last to write
   always_comb begin
      hit = 1'b0;
      idx = '0;
      off = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (hit_vec[i]) begin
            hit = 1'b1;
            idx = IDX_W'(i);
            off = off_vec[i];
         end
      end
   end

endmodule

// File: rtl/bar_cfg_decode.sv
module bar_cfg_decode
   import barcfg_pkg::*;
#(
   parameter int unsigned NUM_BARS     = 6,
   parameter int unsigned ADDR_W       = 32,
   parameter int unsigned CFG_W        = 8,
   parameter int unsigned CMD_W        = 16,
   parameter int unsigned IO_SIZE      = 1,
   parameter int unsigned MEM_SIZE     = 256,
   parameter int unsigned BAR_BASE_OFF = 'h10,
   parameter int unsigned CMD_OFF      = 'h04,
   parameter int unsigned IDX_W        = $clog2(NUM_BARS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CFG_W-1:0]  cfg_addr,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_wdata,
   output logic [ADDR_W-1:0] cfg_rdata,
   input  logic [ADDR_W-1:0] acc_addr,
   output logic              dec_hit,
   output logic [IDX_W-1:0]  dec_idx,
   output logic [ADDR_W-1:0] dec_off
);

   localparam int unsigned WIN_END = BAR_BASE_OFF + 4 * NUM_BARS;

   if (NUM_BARS < 2) begin : g_bad_count
      $error("bar_cfg_decode: at least two slots are required");
   end
   if (IDX_W < $clog2(NUM_BARS)) begin : g_bad_idx
      $error("bar_cfg_decode: IDX_W cannot hold every slot number");
   end
   if ((BAR_BASE_OFF % 4) != 0 || (CMD_OFF % 4) != 0) begin : g_bad_align
      $error("bar_cfg_decode: register offsets must be word aligned");
   end
   if (WIN_END > (1 << CFG_W)) begin : g_bad_window
      $error("bar_cfg_decode: slot window exceeds configuration space");
   end
   if (CMD_OFF >= BAR_BASE_OFF && CMD_OFF < WIN_END) begin : g_bad_overlap
      $error("bar_cfg_decode: command register overlaps the slot window");
   end
   if (CMD_W > ADDR_W) begin : g_bad_cmd
      $error("bar_cfg_decode: command register wider than data");
   end

   // Configuration offset decode
   logic             in_win;
   logic [IDX_W-1:0] bar_sel;
   logic [CFG_W-1:0] win_rel;
   logic             cmd_sel;

   assign win_rel = cfg_addr - CFG_W'(BAR_BASE_OFF);
   assign in_win  = (cfg_addr[1:0] == 2'b00)
                 && ({1'b0, cfg_addr} >= (CFG_W + 1)'(BAR_BASE_OFF))
                 && ({1'b0, cfg_addr} <  (CFG_W + 1)'(WIN_END));
   assign bar_sel = IDX_W'(win_rel >> 2);
   assign cmd_sel = (cfg_addr == CFG_W'(CMD_OFF));

   // Command register
   logic [CMD_W-1:0] cmd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
      end else if (cfg_we && cmd_sel) begin
         cmd_q <= cfg_wdata[CMD_W-1:0];
      end
   end

   // Slots
   logic [NUM_BARS-1:0][ADDR_W-1:0] bar_rd;
   logic [NUM_BARS-1:0][ADDR_W-1:0] bar_off;
   logic [NUM_BARS-1:0]             bar_hit;

   for (genvar i = 0; i < NUM_BARS; i++) begin : g_slot
      logic wr_this;
      assign wr_this = cfg_we && in_win && (bar_sel == IDX_W'(i));

      if (i == 0) begin : g_io
         bar_slot #(
            .ADDR_W (ADDR_W),
            .SPACE  (SP_IO),
            .SIZE   (IO_SIZE)
         ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_this),
            .wdata    (cfg_wdata),
            .rd_value (bar_rd[i]),
            .acc_addr (acc_addr),
            .hit      (bar_hit[i]),
            .offset   (bar_off[i])
         );
      end else if (i == 1) begin : g_mem
         bar_slot #(
            .ADDR_W (ADDR_W),
            .SPACE  (SP_MEM32),
            .SIZE   (MEM_SIZE)
         ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_this),
            .wdata    (cfg_wdata),
            .rd_value (bar_rd[i]),
            .acc_addr (acc_addr),
            .hit      (bar_hit[i]),
            .offset   (bar_off[i])
         );
      end else begin : g_none
         // Unimplemented: no storage, size zero, never decodes
         assign bar_rd[i]  = '0;
         assign bar_hit[i] = 1'b0;
         assign bar_off[i] = '0;
      end
   end

   // Configuration read mux
   always_comb begin
      if (cmd_sel) begin
         cfg_rdata = ADDR_W'(cmd_q);
      end else if (in_win) begin
         cfg_rdata = bar_rd[bar_sel];
      end else begin
         cfg_rdata = '0;
      end
   end

   // Access decode
   bar_first_hit #(
      .N      (NUM_BARS),
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W)
   ) u_pick (
      .hit_vec (bar_hit),
      .off_vec (bar_off),
      .hit     (dec_hit),
      .idx     (dec_idx),
      .off     (dec_off)
   );

endmodule

// File: rtl/bar_cfg_chk.sv
module bar_cfg_chk #(
   parameter int unsigned NUM_BARS     = 6,
   parameter int unsigned ADDR_W       = 32,
   parameter int unsigned CFG_W        = 8,
   parameter int unsigned CMD_W        = 16,
   parameter int unsigned IO_SIZE      = 1,
   parameter int unsigned MEM_SIZE     = 256,
   parameter int unsigned BAR_BASE_OFF = 'h10,
   parameter int unsigned CMD_OFF      = 'h04,
   parameter int unsigned IDX_W        = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CFG_W-1:0]  cfg_addr,
   input logic              cfg_we,
   input logic [ADDR_W-1:0] cfg_wdata,
   input logic [ADDR_W-1:0] cfg_rdata,
   input logic [ADDR_W-1:0] acc_addr,
   input logic              dec_hit,
   input logic [IDX_W-1:0]  dec_idx,
   input logic [ADDR_W-1:0] dec_off
);

   localparam logic [CFG_W-1:0] OFF_B0   = CFG_W'(BAR_BASE_OFF);
   localparam int unsigned      UNIMP_LO = BAR_BASE_OFF + 8;
   localparam int unsigned      UNIMP_HI = BAR_BASE_OFF + 4 * NUM_BARS;

   logic [CMD_W-1:0] cmd_shadow;
   logic             io_written;
   logic             in_unimp;
   logic             acc_unused;

   assign acc_unused = ^acc_addr;
   assign in_unimp = (cfg_addr[1:0] == 2'b00)
                  && ({1'b0, cfg_addr} >= (CFG_W + 1)'(UNIMP_LO))
                  && ({1'b0, cfg_addr} <  (CFG_W + 1)'(UNIMP_HI));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_shadow <= '0;
         io_written <= 1'b0;
      end else if (cfg_we) begin
         if (cfg_addr == CFG_W'(CMD_OFF)) cmd_shadow <= cfg_wdata[CMD_W-1:0];
         if (cfg_addr == OFF_B0)          io_written <= 1'b1;
      end
   end

   assert_cmd_shadow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_addr == CFG_W'(CMD_OFF)) |-> (cfg_rdata == ADDR_W'(cmd_shadow)));

   assert_space_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (io_written && cfg_addr == OFF_B0) |-> cfg_rdata[0]);

   assert_unimpl_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      in_unimp |-> (cfg_rdata == '0));

   assert_io_offset_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_hit && dec_idx == '0) |-> (dec_off < ADDR_W'(IO_SIZE)));

   assert_mem_offset_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_hit && dec_idx == IDX_W'(1)) |-> (dec_off < ADDR_W'(MEM_SIZE)));

   assert_no_size0_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
      dec_hit |-> (dec_idx < IDX_W'(2)));

   assert_miss_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_hit |-> (dec_idx == '0 && dec_off == '0 && !acc_unused | acc_unused));

endmodule

bind bar_cfg_decode bar_cfg_chk #(
   .NUM_BARS     (NUM_BARS),
   .ADDR_W       (ADDR_W),
   .CFG_W        (CFG_W),
   .CMD_W        (CMD_W),
   .IO_SIZE      (IO_SIZE),
   .MEM_SIZE     (MEM_SIZE),
   .BAR_BASE_OFF (BAR_BASE_OFF),
   .CMD_OFF      (CMD_OFF),
   .IDX_W        (IDX_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_addr  (cfg_addr),
   .cfg_we    (cfg_we),
   .cfg_wdata (cfg_wdata),
   .cfg_rdata (cfg_rdata),
   .acc_addr  (acc_addr),
   .dec_hit   (dec_hit),
   .dec_idx   (dec_idx),
   .dec_off   (dec_off)
);

// File: tb/sim_bar_cfg_decode.sv
module sim_bar_cfg_decode;

   localparam int unsigned CFG_W  = 8;
   localparam int unsigned ADDR_W = 32;
   localparam int unsigned IDX_W  = 3;

   // Vector: {op[1:0], sel[7:0], data[31:0], expect[31:0], req[3:0]}
   // op 0 = config write, 1 = config read, 2 = decode (sel = {hit, idx})
   localparam logic [1:0] OP_W = 2'd0;
   localparam logic [1:0] OP_R = 2'd1;
   localparam logic [1:0] OP_D = 2'd2;
   localparam int NV = 42;

   function automatic logic [77:0] mk(logic [1:0] op, logic [7:0] sel,
                                      logic [31:0] data, logic [31:0] ex,
                                      logic [3:0] req);
      return {op, sel, data, ex, req};
   endfunction

   localparam logic [77:0] VEC [NV] = '{
      mk(OP_W, 8'h04, 32'hABCD1234, 32'h0,        4'd2),  // R2 upper half dropped
      mk(OP_R, 8'h04, 32'h0,        32'h00001234, 4'd2),
      mk(OP_W, 8'h10, 32'h00001000, 32'h0,        4'd3),  // R3 bit 0 forced
      mk(OP_R, 8'h10, 32'h0,        32'h00001001, 4'd3),
      mk(OP_W, 8'h14, 32'h80000000, 32'h0,        4'd4),  // R4
      mk(OP_R, 8'h14, 32'h0,        32'h80000000, 4'd4),
      mk(OP_D, 8'h08, 32'h00001000, 32'h0,        4'd8),  // R8 slot 0
      mk(OP_D, 8'h00, 32'h00001001, 32'h0,        4'd10), // R10 past slot 0
      mk(OP_D, 8'h09, 32'h80000010, 32'h10,       4'd8),  // R8 slot 1
      mk(OP_D, 8'h09, 32'h800000FF, 32'hFF,       4'd8),  // R8 last byte
      mk(OP_D, 8'h00, 32'h80000100, 32'h0,        4'd10), // R10 one past
      mk(OP_D, 8'h00, 32'h7FFFFFFF, 32'h0,        4'd10), // R10 one below
      mk(OP_W, 8'h18, 32'h12345678, 32'h0,        4'd5),  // R5
      mk(OP_R, 8'h18, 32'h0,        32'h0,        4'd5),
      mk(OP_W, 8'h24, 32'hFFFFFFFF, 32'h0,        4'd5),
      mk(OP_R, 8'h24, 32'h0,        32'h0,        4'd5),
      mk(OP_W, 8'h08, 32'hFFFFFFFF, 32'h0,        4'd11), // R11 stray offset
      mk(OP_R, 8'h08, 32'h0,        32'h0,        4'd11),
      mk(OP_R, 8'h04, 32'h0,        32'h00001234, 4'd11),
      mk(OP_R, 8'h10, 32'h0,        32'h00001001, 4'd11),
      mk(OP_R, 8'h14, 32'h0,        32'h80000000, 4'd11),
      mk(OP_R, 8'h11, 32'h0,        32'h0,        4'd11), // R11 unaligned
      mk(OP_W, 8'h10, 32'hFFFFFFFF, 32'h0,        4'd6),  // R6 probe
      mk(OP_R, 8'h10, 32'h0,        32'hFFFFFFFD, 4'd6),
      mk(OP_W, 8'h10, 32'hFFFFFFFE, 32'h0,        4'd6),  // R6 via forced bit
      mk(OP_R, 8'h10, 32'h0,        32'hFFFFFFFD, 4'd6),
      mk(OP_W, 8'h14, 32'hFFFFFFFF, 32'h0,        4'd7),  // R7 probe
      mk(OP_R, 8'h14, 32'h0,        32'hFFFFFF00, 4'd7),
      mk(OP_D, 8'h08, 32'hFFFFFFFE, 32'h0,        4'd9),  // R9 both contain it
      mk(OP_D, 8'h09, 32'hFFFFFFFF, 32'h1,        4'd12), // R12 top of space
      mk(OP_W, 8'h10, 32'h00000000, 32'h0,        4'd3),
      mk(OP_R, 8'h10, 32'h0,        32'h00000001, 4'd3),
      mk(OP_W, 8'h14, 32'h00000000, 32'h0,        4'd9),
      mk(OP_D, 8'h08, 32'h00000000, 32'h0,        4'd9),  // R9 overlap at 0
      mk(OP_D, 8'h09, 32'h00000005, 32'h5,        4'd9),
      mk(OP_D, 8'h00, 32'h00000100, 32'h0,        4'd10),
      mk(OP_W, 8'h14, 32'h000000FF, 32'h0,        4'd4),
      mk(OP_R, 8'h14, 32'h0,        32'h000000FF, 4'd4),
      mk(OP_D, 8'h09, 32'h000000FE, 32'h0,        4'd8),  // R8 base bit 0 cleared
      mk(OP_D, 8'h00, 32'h000000FD, 32'h0,        4'd8),
      mk(OP_W, 8'h04, 32'hFFFFFFFF, 32'h0,        4'd2),
      mk(OP_R, 8'h04, 32'h0,        32'h0000FFFF, 4'd2)
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [CFG_W-1:0]  cfg_addr = '0;
   logic              cfg_we = 1'b0;
   logic [ADDR_W-1:0] cfg_wdata = '0;
   logic [ADDR_W-1:0] cfg_rdata;
   logic [ADDR_W-1:0] acc_addr = '0;
   logic              dec_hit;
   logic [IDX_W-1:0]  dec_idx;
   logic [ADDR_W-1:0] dec_off;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   bar_cfg_decode u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_addr  (cfg_addr),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .acc_addr  (acc_addr),
      .dec_hit   (dec_hit),
      .dec_idx   (dec_idx),
      .dec_off   (dec_off)
   );

   task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_addr  = a;
      cfg_wdata = d;
      cfg_we    = 1'b1;
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   task automatic cfg_read(input logic [7:0] a, input logic [31:0] ex, input string req);
      @(negedge clk);
      cfg_addr = a;
      #1;
      check(req, {4'h0, cfg_rdata}, {4'h0, ex});
   endtask

   task automatic decode(input logic [31:0] a, input logic h, input logic [2:0] i,
                         input logic [31:0] off, input string req);
      @(negedge clk);
      acc_addr = a;
      #1;
      check(req, {dec_hit, dec_idx, dec_off}, {h, i, off});
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 10);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      cfg_read(8'h04, 32'h0, "R1");
      for (int k = 0; k < 6; k++) cfg_read(8'(8'h10 + 4 * k), 32'h0, "R1");

      for (int v = 0; v < NV; v++) begin
         logic [1:0]  op;
         logic [7:0]  sel;
         logic [31:0] data;
         logic [31:0] ex;
         logic [3:0]  rq;
         string       tag;
         {op, sel, data, ex, rq} = VEC[v];
         tag = $sformatf("R%0d vec%0d", rq, v);
         case (op)
            OP_W:    cfg_write(sel, data);
            OP_R:    cfg_read(sel, ex, tag);
            default: decode(data, sel[3], sel[2:0], ex, tag);
         endcase
      end

      // R1 reset in mid-run clears everything again
      cfg_write(8'h10, 32'h00004000);
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      cfg_read(8'h10, 32'h0, "R1 after reset");
      cfg_read(8'h14, 32'h0, "R1 after reset");
      cfg_read(8'h04, 32'h0, "R1 after reset");
      decode(32'h00000000, 1'b1, 3'd0, 32'h0, "R1 slot 0 at base 0");

      // R10 sizing probe on unimplemented slots still decodes nothing
      cfg_write(8'h1C, 32'hFFFFFFFF);
      cfg_read(8'h1C, 32'h0, "R5 probe");
      cfg_write(8'h10, 32'h00100000);
      cfg_write(8'h14, 32'h00200000);
      decode(32'h00300000, 1'b0, 3'd0, 32'h0, "R10 miss");

      finish_run();
   end

endmodule